// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one multiprocessor and decides, one request at a time, whether a pending thread block can become resident there. A request carries the block's thread count and its shared-memory need in bytes. The block is taken whole or not at all. The controller takes it only if three limits still hold with the block added: the number of resident blocks, the total resident threads, and the total shared-memory bytes.

The admission decision is combinational within the request cycle. A granted block receives a slot number, and the controller keeps that slot's threads and bytes until a release names the slot. A request that could never fit, even on an empty multiprocessor, is flagged as a permanent rejection. A request that only lacks room at present is flagged as a retry-later refusal.

Registered occupancy counters and an any-slot-free flag show the current load.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After reset the three occupancy counters read zero and `slot_avail` is 1.
- R2: No more than SLOTS (default 8) blocks are ever resident; a request that would need a ninth slot is refused with `adm_full`.
- R3: The sum of resident threads never exceeds MAX_THREADS (default 768); a request that would push the sum past it is refused with `adm_full`.
- R4: The sum of resident shared-memory bytes never exceeds SMEM_BYTES (default 16384); a request that would push it past is refused with `adm_full`.
- R5: A request whose thread count exceeds MAX_THREADS, or whose byte need exceeds SMEM_BYTES, raises `adm_reject` and changes no counter.
- R6: While `req_valid` is 1, exactly one of `adm_grant`, `adm_full` and `adm_reject` is 1. While it is 0, all three are 0. A refused request changes no counter.
- R7: A grant allocates the lowest-numbered free slot, reported on `adm_slot`. On the next clock `occ_blocks` rises by one and the other two counters rise by the request's amounts.
- R8: A valid release frees its slot's blocks, threads and bytes in the same cycle. A request in that cycle is judged against the freed resources and may reuse that slot.
- R9: A release naming a slot that is not in use raises `rel_err` in that cycle and changes no counter.
- R10: With 64-thread blocks that need no shared memory, eight blocks (512 threads) become resident. With 256-thread blocks, three are admitted (768 threads) and the fourth is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present this cycle |
| req_threads | input | REQ_THR_W (11) | Threads in the requested block |
| req_smem | input | REQ_SMEM_W (15) | Shared-memory bytes the block needs |
| adm_grant | output | 1 | Block accepted this cycle |
| adm_slot | output | SLOT_W (3) | Slot given to the accepted block |
| adm_full | output | 1 | Refused for lack of room now |
| adm_reject | output | 1 | Refused permanently: can never fit |
| rel_valid | input | 1 | Release a resident block |
| rel_slot | input | SLOT_W (3) | Slot being released |
| rel_err | output | 1 | Release named a slot not in use |
| occ_blocks | output | CNT_W (4) | Resident block count |
| occ_threads | output | THR_W (10) | Resident thread total |
| occ_smem | output | SM_W (15) | Resident shared-memory bytes |
| slot_avail | output | 1 | At least one slot is free |

## Verification
On every cycle, the assertions check the following: the three occupancy ceilings, that exactly one response is given per request, that a grant adds one block, that refusals and bad releases leave the counters untouched, and that the free-slot flag agrees with the block count. Some behaviours depend on history, and only the bench's reference model can show them: which slot is lowest free after a mixed history of releases, a request reusing a slot freed in the same cycle, and the exact stopping points for 64-thread and 256-thread blocks.

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int SLOTS       = 8,
  parameter int MAX_THREADS = 768,
  parameter int SMEM_BYTES  = 16384,
  parameter int REQ_THR_W   = 11,
  parameter int REQ_SMEM_W  = 15,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int SM_W   = $clog2(SMEM_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [REQ_THR_W-1:0]  req_threads,
  input  logic [REQ_SMEM_W-1:0] req_smem,
  output logic                  adm_grant,
  output logic [SLOT_W-1:0]     adm_slot,
  output logic                  adm_full,
  output logic                  adm_reject,
  input  logic                  rel_valid,
  input  logic [SLOT_W-1:0]     rel_slot,
  output logic                  rel_err,
  output logic [CNT_W-1:0]      occ_blocks,
  output logic [THR_W-1:0]      occ_threads,
  output logic [SM_W-1:0]       occ_smem,
  output logic                  slot_avail
);
  localparam int ST_W = ((REQ_THR_W > THR_W) ? REQ_THR_W : THR_W) + 1;
  localparam int SS_W = ((REQ_SMEM_W > SM_W) ? REQ_SMEM_W : SM_W) + 1;

  logic [SLOTS-1:0] used_q;
  logic [THR_W-1:0] thr_q [SLOTS];
  logic [SM_W-1:0]  sm_q  [SLOTS];
  logic [CNT_W-1:0] blk_q;
  logic [THR_W-1:0] tot_thr_q;
  logic [SM_W-1:0]  tot_sm_q;

  logic             rel_ok;
  logic [SLOTS-1:0] rel_mask, used_eff, grant_mask;
  logic [CNT_W-1:0] blk_eff;
  logic [THR_W-1:0] thr_eff;
  logic [SM_W-1:0]  sm_eff;
  logic             too_big, fits;
  logic [SLOT_W-1:0] pick;

  assign rel_ok   = rel_valid && used_q[rel_slot];
  assign rel_err  = rel_valid && !rel_ok;
  assign rel_mask = rel_ok ? (SLOTS'(1) << rel_slot) : '0;
  assign used_eff = used_q & ~rel_mask;
  assign blk_eff  = blk_q - (rel_ok ? CNT_W'(1) : '0);
  assign thr_eff  = tot_thr_q - (rel_ok ? thr_q[rel_slot] : '0);
  assign sm_eff   = tot_sm_q - (rel_ok ? sm_q[rel_slot] : '0);

  assign too_big = (ST_W'(req_threads) > ST_W'(MAX_THREADS)) ||
                   (SS_W'(req_smem) > SS_W'(SMEM_BYTES));
  assign fits = (blk_eff < CNT_W'(SLOTS)) &&
                (ST_W'(thr_eff) + ST_W'(req_threads) <= ST_W'(MAX_THREADS)) &&
                (SS_W'(sm_eff) + SS_W'(req_smem) <= SS_W'(SMEM_BYTES));

  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!used_eff[i]) pick = SLOT_W'(i);
  end

  assign adm_grant  = req_valid && !too_big && fits;
  assign adm_full   = req_valid && !too_big && !fits;
  assign adm_reject = req_valid && too_big;
  assign adm_slot   = pick;
  assign grant_mask = adm_grant ? (SLOTS'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q    <= '0;
      blk_q     <= '0;
      tot_thr_q <= '0;
      tot_sm_q  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        thr_q[i] <= '0;
        sm_q[i]  <= '0;
      end
    end else begin
      used_q    <= used_eff | grant_mask;
      blk_q     <= blk_eff + (adm_grant ? CNT_W'(1) : '0);
      tot_thr_q <= thr_eff + (adm_grant ? THR_W'(req_threads) : '0);
      tot_sm_q  <= sm_eff + (adm_grant ? SM_W'(req_smem) : '0);
      if (adm_grant) begin
        thr_q[pick] <= THR_W'(req_threads);
        sm_q[pick]  <= SM_W'(req_smem);
      end
    end
  end

  assign occ_blocks  = blk_q;
  assign occ_threads = tot_thr_q;
  assign occ_smem    = tot_sm_q;
  assign slot_avail  = ~&used_q;
endmodule

// File: rtl/blk_admit_ctrl_chk.sv
module blk_admit_ctrl_chk #(
  parameter int SLOTS = 8, MAX_THREADS = 768, SMEM_BYTES = 16384,
  parameter int CNT_W = 4, THR_W = 10, SM_W = 15
) (
  input logic clk, rst_n, req_valid, adm_grant, adm_full, adm_reject,
  input logic rel_valid, rel_err, slot_avail,
  input logic [CNT_W-1:0] occ_blocks,
  input logic [THR_W-1:0] occ_threads,
  input logic [SM_W-1:0]  occ_smem
);
  a_r2_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occ_blocks <= CNT_W'(SLOTS));
  a_r3_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_threads) <= MAX_THREADS);
  a_r4_smem_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_smem) <= SMEM_BYTES);
  a_r6_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({adm_grant, adm_full, adm_reject}) == 1);
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !adm_grant && !adm_full && !adm_reject);
  a_r7_grant_adds: assert property (@(posedge clk) disable iff (!rst_n)
    adm_grant && !rel_valid |=> occ_blocks == $past(occ_blocks) + CNT_W'(1));
  a_r5_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (adm_reject || adm_full) && !rel_valid |=>
      $stable(occ_blocks) && $stable(occ_threads) && $stable(occ_smem));
  a_r9_bad_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err && !adm_grant |=> $stable(occ_blocks) && $stable(occ_threads));
  a_r1_avail_flag: assert property (@(posedge clk) disable iff (!rst_n)
    slot_avail == (occ_blocks < CNT_W'(SLOTS)));
endmodule

bind blk_admit_ctrl blk_admit_ctrl_chk #(
  .SLOTS(SLOTS), .MAX_THREADS(MAX_THREADS), .SMEM_BYTES(SMEM_BYTES),
  .CNT_W(CNT_W), .THR_W(THR_W), .SM_W(SM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .adm_grant(adm_grant),
  .adm_full(adm_full), .adm_reject(adm_reject), .rel_valid(rel_valid),
  .rel_err(rel_err), .slot_avail(slot_avail), .occ_blocks(occ_blocks),
  .occ_threads(occ_threads), .occ_smem(occ_smem)
);

// File: tb/blk_admit_ctrl_tb.sv
`timescale 1ns/100ps
module blk_admit_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rel_valid = 0;
  logic [10:0] req_threads = 0;
  logic [14:0] req_smem = 0;
  logic [2:0] rel_slot = 0;
  logic adm_grant, adm_full, adm_reject, rel_err, slot_avail;
  logic [2:0] adm_slot;
  logic [3:0] occ_blocks;
  logic [9:0] occ_threads;
  logic [14:0] occ_smem;

  int errors = 0, checks = 0;
  bit m_used [8];
  int m_thr [8];
  int m_sm [8];

  always #2.5 clk = ~clk;

  blk_admit_ctrl u_dut (.*);

  task automatic step(input bit rv, input int rt, input int rs,
                      input bit lv, input int ls, input string tag);
    bit rok, big, fit, eg, ef, er;
    int blk, thr, sm, pk, eblk, ethr, esm;
    @(negedge clk);
    req_valid = rv; req_threads = 11'(rt); req_smem = 15'(rs);
    rel_valid = lv; rel_slot = 3'(ls);
    #1;
    blk = 0; thr = 0; sm = 0;
    for (int i = 0; i < 8; i++) if (m_used[i]) begin blk++; thr += m_thr[i]; sm += m_sm[i]; end
    eblk = blk; ethr = thr; esm = sm;
    rok = lv && m_used[ls];
    if (rok) begin blk--; thr -= m_thr[ls]; sm -= m_sm[ls]; end
    pk = -1;
    for (int i = 7; i >= 0; i--) if (!m_used[i] || (rok && i == ls)) pk = i;
    big = (rt > 768) || (rs > 16384);
    fit = (blk < 8) && (thr + rt <= 768) && (sm + rs <= 16384);
    eg = rv && !big && fit; ef = rv && !big && !fit; er = rv && big;
    checks++;
    if (adm_grant !== eg || adm_full !== ef || adm_reject !== er ||
        (eg && adm_slot !== 3'(pk)) || rel_err !== (lv && !rok) ||
        occ_blocks !== 4'(eblk) || occ_threads !== 10'(ethr) ||
        occ_smem !== 15'(esm) || slot_avail !== (eblk < 8)) begin
      errors++;
      $display("FAIL %s: got g%0d f%0d r%0d s%0d e%0d b%0d t%0d m%0d exp g%0d f%0d r%0d s%0d e%0d b%0d t%0d m%0d",
        tag, adm_grant, adm_full, adm_reject, adm_slot, rel_err, occ_blocks, occ_threads, occ_smem,
        eg, ef, er, pk, lv && !rok, eblk, ethr, esm);
    end
    @(posedge clk);
    if (rok) m_used[ls] = 0;
    if (eg) begin m_used[pk] = 1; m_thr[pk] = rt; m_sm[pk] = rs; end
  endtask

  task automatic clear_all(input string tag);
    for (int s = 0; s < 8; s++) step(0, 0, 0, 1, s, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_used[i] = 0; m_thr[i] = 0; m_sm[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 0, 0, 0, "R1 reset state");
    for (int k = 0; k < 9; k++) step(1, 64, 0, 0, 0, "R10 R2 64-thread fill");
    step(0, 0, 0, 0, 0, "R2 eight resident");
    clear_all("R9 drain");
    for (int k = 0; k < 4; k++) step(1, 256, 0, 0, 0, "R10 R3 256-thread fill");
    step(1, 256, 0, 1, 1, "R8 release and admit same cycle");
    step(0, 0, 0, 1, 5, "R9 release unused slot");
    step(1, 769, 0, 0, 0, "R5 too many threads");
    step(1, 1, 16385, 0, 0, "R5 too much smem");
    step(1, 1024, 0, 0, 0, "R5 far over thread cap");
    clear_all("R9 drain");
    step(1, 32, 8192, 0, 0, "R4 half smem");
    step(1, 32, 8192, 0, 0, "R4 full smem");
    step(1, 32, 1, 0, 0, "R4 one byte over");
    step(1, 32, 0, 0, 0, "R4 zero bytes fits");
    step(0, 0, 0, 1, 0, "R7 free slot 0");
    step(1, 16, 0, 0, 0, "R7 lowest slot reused");
    step(1, 16, 0, 0, 0, "R7 next slot");
    step(1, 16, 0, 0, 0, "R6 idle-free check");
    clear_all("R9 drain");
    for (int k = 0; k < 2000; k++) begin
      int rt, rs;
      rt = ($urandom_range(0, 15) == 0) ? 800 : $urandom_range(1, 300);
      rs = ($urandom_range(0, 15) == 0) ? 20000 : $urandom_range(0, 5000);
      step($urandom_range(0, 1) == 1, rt, rs, $urandom_range(0, 2) == 0,
           $urandom_range(0, 7), "R6 R7 R8 mixed traffic");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule